// File: doc/BRIEF.md
# Frame Statistics Counter Bank

This block keeps network-monitoring statistics for a receive path. The frame parser presents one summary per finished frame as a single-cycle strobe. The summary carries the byte length and a set of flags: bad CRC, alignment error, symbol error, broadcast destination, multicast destination, MAC control frame, and pause opcode. Each summary is classified in one registered stage. On the following clock edge every counter the frame qualifies for is advanced at the same time. The bank holds 22 counters: totals, a frame-size histogram, size/CRC categories and error categories.

Software reads a counter through a single-cycle read port. The value appears one cycle after the request. By default a read also zeroes the counter it returned. Writing a one to the keep-on-read control bit (bit 0 of the control register, written through `ctl_we`/`ctl_keep`) switches reads to non-destructive.

The read side is a two-state machine. In `RD_IDLE` no response is pending. Transition `IDLE_TO_RESP` is taken on `rd_en` and moves to `RD_RESP`, where `rd_valid` is high for one cycle. Transition `RESP_TO_RESP` is taken on a back-to-back request, and transition `RESP_TO_IDLE` is taken when there is no new request.

Top module: `rmon_stats`

## Requirements
- R1: After reset every counter reads zero, `rd_valid` is low and `rd_data` is zero.
- R2: Every frame adds 1 to the all-frames counter (address 3) and adds its length to the all-octets counter (address 2), whatever its flags.
- R3: A frame is good when its CRC is good, it has no alignment or symbol error, and its length is from 64 to 1518 inclusive. Good frames add 1 at address 1 and their length at address 0. Good frames with the broadcast flag add 1 at address 4. Good frames with the multicast flag add 1 at address 5.
- R4: Every frame is placed in at most one length bin: exactly 64 (address 6), 65–127 (7), 128–255 (8), 256–511 (9), 512–1023 (10), 1024–1518 (11). Lengths outside 64–1518 fall in no bin.
- R5: A length above 1518 counts as jabber when the CRC is bad (address 12) and as oversize when the CRC is good (address 13).
- R6: A length below 64 counts as a fragment when the CRC is bad (address 14) and as undersize when the CRC is good (address 15).
- R7: CRC-or-alignment error adds 1 at address 16. A CRC error without an alignment error adds 1 at address 17. An alignment error without a CRC error adds 1 at address 18.
- R8: The symbol-error flag adds 1 at address 19. A control frame with the pause flag adds 1 at address 20. A control frame without the pause flag adds 1 at address 21.
- R9: `rd_valid` is high in exactly the cycle after a cycle with `rd_en`. `rd_data` then holds the counter's value from before that edge. An address of 22 or more returns zero.
- R10: A read clears the counter it returns unless the keep bit is set. Reads issued while the keep bit is set leave the counter unchanged.
- R11: When a clearing read and a frame increment reach the same counter on the same edge, the counter ends at the increment. The increment is not lost.
- R12: Counters wrap modulo 2^CNT_W, which is 32 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fr_valid | input | 1 | One-cycle strobe: frame summary present |
| fr_len | input | LEN_W | Frame length in bytes |
| fr_crc_bad | input | 1 | CRC check failed |
| fr_align_err | input | 1 | Frame not a whole number of octets |
| fr_symbol_err | input | 1 | Line symbol error seen during frame |
| fr_bcast | input | 1 | Destination is broadcast |
| fr_mcast | input | 1 | Destination is multicast |
| fr_ctrl | input | 1 | MAC control frame |
| fr_pause | input | 1 | Control frame carries the pause opcode |
| ctl_we | input | 1 | Write strobe for the control bit |
| ctl_keep | input | 1 | Control bit 0: 1 keeps counters on read |
| rd_en | input | 1 | Read request |
| rd_addr | input | 5 | Counter address |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | CNT_W | Counter value returned |

## Verification
A counter is visible only through a read, so a wrong internal count stays hidden until that address is read. It then shows as a wrong `rd_data` one cycle after the request. A misclassified frame shows at two or more addresses at once: the total it was added to and the category it was wrongly put in or left out of. A read machine left in the wrong state shows up on `rd_valid` in the very next cycle. A lost or spurious clear shows on the second read of the same address. A narrow-counter instance makes the wrap-around visible within a few dozen frames.

// File: rtl/rmon_pkg.sv
package rmon_pkg;

    localparam int NUM_CNT = 22;
    localparam int ADDR_W  = 5;

    typedef enum logic [4:0] {
        CI_GOOD_OCT     = 5'd0,
        CI_GOOD_PKT     = 5'd1,
        CI_ALL_OCT      = 5'd2,
        CI_ALL_PKT      = 5'd3,
        CI_GOOD_BCAST   = 5'd4,
        CI_GOOD_MCAST   = 5'd5,
        CI_BIN64        = 5'd6,
        CI_BIN65        = 5'd7,
        CI_BIN128       = 5'd8,
        CI_BIN256       = 5'd9,
        CI_BIN512       = 5'd10,
        CI_BIN1024      = 5'd11,
        CI_JABBER       = 5'd12,
        CI_OVERSIZE     = 5'd13,
        CI_FRAGMENT     = 5'd14,
        CI_UNDERSIZE    = 5'd15,
        CI_CRC_OR_ALIGN = 5'd16,
        CI_CRC_ONLY     = 5'd17,
        CI_ALIGN_ONLY   = 5'd18,
        CI_SYMBOL       = 5'd19,
        CI_PAUSE        = 5'd20,
        CI_OTHER_CTRL   = 5'd21
    } cnt_idx_e;

    typedef struct packed {
        logic crc_bad;
        logic align_err;
        logic symbol_err;
        logic bcast;
        logic mcast;
        logic ctrl;
        logic pause;
    } frame_flags_t;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_RESP = 1'b1
    } rd_state_e;

endpackage

// File: rtl/rmon_classify.sv
module rmon_classify
    import rmon_pkg::*;
#(
    parameter int LEN_W   = 14,
    parameter int MIN_LEN = 64,
    parameter int MAX_LEN = 1518
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fr_valid,
    input  logic [LEN_W-1:0]     fr_len,
    input  frame_flags_t         fr_flags,
    output logic [NUM_CNT-1:0]   ev_q,
    output logic [LEN_W-1:0]     len_q
);

    localparam logic [LEN_W-1:0] L_MIN  = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] L_MAX  = LEN_W'(MAX_LEN);
    localparam logic [LEN_W-1:0] L_127  = LEN_W'(127);
    localparam logic [LEN_W-1:0] L_255  = LEN_W'(255);
    localparam logic [LEN_W-1:0] L_511  = LEN_W'(511);
    localparam logic [LEN_W-1:0] L_1023 = LEN_W'(1023);

    logic [NUM_CNT-1:0] ev_d;
    logic               is_short;
    logic               is_long;
    logic               is_good;
    logic               crc_ok;

    always_comb begin
        crc_ok   = !fr_flags.crc_bad;
        is_short = fr_len < L_MIN;
        is_long  = fr_len > L_MAX;
        is_good  = crc_ok && !fr_flags.align_err && !fr_flags.symbol_err
                   && !is_short && !is_long;
        ev_d     = '0;
        if (fr_valid) begin
            ev_d[int'(CI_ALL_PKT)]      = 1'b1;
            ev_d[int'(CI_ALL_OCT)]      = 1'b1;
            ev_d[int'(CI_GOOD_PKT)]     = is_good;
            ev_d[int'(CI_GOOD_OCT)]     = is_good;
            ev_d[int'(CI_GOOD_BCAST)]   = is_good && fr_flags.bcast;
            ev_d[int'(CI_GOOD_MCAST)]   = is_good && fr_flags.mcast;
            ev_d[int'(CI_BIN64)]        = fr_len == L_MIN;
            ev_d[int'(CI_BIN65)]        = fr_len > L_MIN  && fr_len <= L_127;
            ev_d[int'(CI_BIN128)]       = fr_len > L_127  && fr_len <= L_255;
            ev_d[int'(CI_BIN256)]       = fr_len > L_255  && fr_len <= L_511;
            ev_d[int'(CI_BIN512)]       = fr_len > L_511  && fr_len <= L_1023;
            ev_d[int'(CI_BIN1024)]      = fr_len > L_1023 && !is_long;
            ev_d[int'(CI_JABBER)]       = is_long  && !crc_ok;
            ev_d[int'(CI_OVERSIZE)]     = is_long  && crc_ok;
            ev_d[int'(CI_FRAGMENT)]     = is_short && !crc_ok;
            ev_d[int'(CI_UNDERSIZE)]    = is_short && crc_ok;
            ev_d[int'(CI_CRC_OR_ALIGN)] = !crc_ok || fr_flags.align_err;
            ev_d[int'(CI_CRC_ONLY)]     = !crc_ok && !fr_flags.align_err;
            ev_d[int'(CI_ALIGN_ONLY)]   = crc_ok && fr_flags.align_err;
            ev_d[int'(CI_SYMBOL)]       = fr_flags.symbol_err;
            ev_d[int'(CI_PAUSE)]        = fr_flags.ctrl && fr_flags.pause;
            ev_d[int'(CI_OTHER_CTRL)]   = fr_flags.ctrl && !fr_flags.pause;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_q  <= '0;
            len_q <= '0;
        end else begin
            ev_q  <= ev_d;
            len_q <= fr_len;
        end
    end

    // R2: every strobe yields exactly one all-frames event with its length
    a_r2_frame_counted: assert property (@(posedge clk) disable iff (!rst_n)
        fr_valid |=> (ev_q[int'(CI_ALL_PKT)] && len_q == $past(fr_len)));

    a_r2_idle_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        !fr_valid |=> (ev_q == '0));

    // R4: a frame lands in at most one histogram bin
    a_r4_single_bin: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ev_q[int'(CI_BIN1024):int'(CI_BIN64)]));

    // R5, R6: the four size/CRC classes never overlap
    a_r5_size_class_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ev_q[int'(CI_UNDERSIZE):int'(CI_JABBER)]));

    // R7: CRC-only and alignment-only never both fire
    a_r7_error_split: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_q[int'(CI_CRC_ONLY)] && ev_q[int'(CI_ALIGN_ONLY)]));

endmodule

// File: rtl/rmon_counter.sv
module rmon_counter #(
    parameter int CNT_W = 32,
    parameter int ADD_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [ADD_W-1:0] add_i,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] base;

    always_comb begin
        base = clr_i ? '0 : cnt_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else begin
            cnt_o <= base + CNT_W'(add_i);
        end
    end

    // R10: a clear with nothing to add leaves zero
    a_r10_clear_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && add_i == '0) |=> (cnt_o == '0));

    // R11: a clear coinciding with an increment keeps the increment
    a_r11_clear_keeps_inc: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_o == CNT_W'($past(add_i))));

    // R10: no clear and nothing to add holds the value
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && add_i == '0) |=> $stable(cnt_o));

endmodule

// File: rtl/rmon_readout.sv
module rmon_readout
    import rmon_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int NUM   = NUM_CNT
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd_en,
    input  logic [ADDR_W-1:0]          rd_addr,
    input  logic                       ctl_we,
    input  logic                       ctl_keep,
    input  logic [NUM-1:0][CNT_W-1:0]  cnt_all,
    output logic                       rd_valid,
    output logic [CNT_W-1:0]           rd_data,
    output logic [NUM-1:0]             clr
);

    rd_state_e state_q;
    rd_state_e state_d;
    logic      keep_q;
    logic      in_range;

    always_comb begin
        in_range = int'(rd_addr) < NUM;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: if (rd_en)  state_d = RD_RESP;   // IDLE_TO_RESP
            RD_RESP: if (!rd_en) state_d = RD_IDLE;   // RESP_TO_IDLE, else RESP_TO_RESP
            default: state_d = RD_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
            keep_q  <= 1'b0;
        end else begin
            if (rd_en) rd_data <= in_range ? cnt_all[rd_addr] : '0;
            if (ctl_we) keep_q <= ctl_keep;
        end
    end

    always_comb begin
        rd_valid = (state_q == RD_RESP);
        for (int i = 0; i < NUM; i++) begin
            clr[i] = rd_en && !keep_q && (rd_addr == ADDR_W'(i));
        end
    end

    // R9: response exactly one cycle after each request
    a_r9_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    a_r9_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    // R9: unmapped addresses answer zero
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !in_range) |=> (rd_data == '0));

    // R10: keep bit suppresses every clear, and at most one clear at a time
    a_r10_keep_blocks_clear: assert property (@(posedge clk) disable iff (!rst_n)
        keep_q |-> (clr == '0));

    a_r10_one_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr));

endmodule

// File: rtl/rmon_stats.sv
module rmon_stats
    import rmon_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int LEN_W   = 14,
    parameter int MIN_LEN = 64,
    parameter int MAX_LEN = 1518
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fr_valid,
    input  logic [LEN_W-1:0]  fr_len,
    input  logic              fr_crc_bad,
    input  logic              fr_align_err,
    input  logic              fr_symbol_err,
    input  logic              fr_bcast,
    input  logic              fr_mcast,
    input  logic              fr_ctrl,
    input  logic              fr_pause,
    input  logic              ctl_we,
    input  logic              ctl_keep,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [CNT_W-1:0]  rd_data
);

    frame_flags_t                    flags;
    logic [NUM_CNT-1:0]              ev_q;
    logic [LEN_W-1:0]                len_q;
    logic [NUM_CNT-1:0]              clr;
    logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_all;

    always_comb begin
        flags.crc_bad    = fr_crc_bad;
        flags.align_err  = fr_align_err;
        flags.symbol_err = fr_symbol_err;
        flags.bcast      = fr_bcast;
        flags.mcast      = fr_mcast;
        flags.ctrl       = fr_ctrl;
        flags.pause      = fr_pause;
    end

    rmon_classify #(
        .LEN_W  (LEN_W),
        .MIN_LEN(MIN_LEN),
        .MAX_LEN(MAX_LEN)
    ) u_classify (
        .clk     (clk),
        .rst_n   (rst_n),
        .fr_valid(fr_valid),
        .fr_len  (fr_len),
        .fr_flags(flags),
        .ev_q    (ev_q),
        .len_q   (len_q)
    );

    for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
        logic [LEN_W-1:0] add_w;
        if (gi == int'(CI_GOOD_OCT) || gi == int'(CI_ALL_OCT)) begin : g_octets
            assign add_w = ev_q[gi] ? len_q : '0;
        end else begin : g_frames
            assign add_w = {{(LEN_W-1){1'b0}}, ev_q[gi]};
        end
        rmon_counter #(
            .CNT_W(CNT_W),
            .ADD_W(LEN_W)
        ) u_cnt (
            .clk  (clk),
            .rst_n(rst_n),
            .clr_i(clr[gi]),
            .add_i(add_w),
            .cnt_o(cnt_all[gi])
        );
    end

    rmon_readout #(
        .CNT_W(CNT_W),
        .NUM  (NUM_CNT)
    ) u_readout (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .ctl_we  (ctl_we),
        .ctl_keep(ctl_keep),
        .cnt_all (cnt_all),
        .rd_valid(rd_valid),
        .rd_data (rd_data),
        .clr     (clr)
    );

endmodule

// File: tb/sim_rmon_stats.sv
`timescale 1ns/1ps
module sim_rmon_stats;

    localparam int NC = 22;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fr_valid = 1'b0;
    logic [13:0] fr_len = '0;
    logic        fr_crc_bad = 1'b0, fr_align_err = 1'b0, fr_symbol_err = 1'b0;
    logic        fr_bcast = 1'b0, fr_mcast = 1'b0, fr_ctrl = 1'b0, fr_pause = 1'b0;
    logic        ctl_we = 1'b0, ctl_keep = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  rd_addr = '0;
    logic        rd_valid0, rd_valid1;
    logic [31:0] rd_data0;
    logic [11:0] rd_data1;

    always #4 clk = ~clk;

    rmon_stats u0 (
        .clk(clk), .rst_n(rst_n), .fr_valid(fr_valid), .fr_len(fr_len),
        .fr_crc_bad(fr_crc_bad), .fr_align_err(fr_align_err),
        .fr_symbol_err(fr_symbol_err), .fr_bcast(fr_bcast), .fr_mcast(fr_mcast),
        .fr_ctrl(fr_ctrl), .fr_pause(fr_pause), .ctl_we(ctl_we), .ctl_keep(ctl_keep),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid0), .rd_data(rd_data0)
    );

    // narrow instance to exercise wrap-around (R12)
    rmon_stats #(.CNT_W(12)) u1 (
        .clk(clk), .rst_n(rst_n), .fr_valid(fr_valid), .fr_len(fr_len),
        .fr_crc_bad(fr_crc_bad), .fr_align_err(fr_align_err),
        .fr_symbol_err(fr_symbol_err), .fr_bcast(fr_bcast), .fr_mcast(fr_mcast),
        .fr_ctrl(fr_ctrl), .fr_pause(fr_pause), .ctl_we(ctl_we), .ctl_keep(ctl_keep),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid1), .rd_data(rd_data1)
    );

    int     checks = 0;
    int     errors = 0;
    string  tag = "";
    longint m [NC];
    longint p [NC];
    logic   keep_m;
    logic   exp_valid;
    longint exp_data;
    int     exp_addr;

    task automatic chk(input string req, input longint act, input longint expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic string req_of(input int a);
        if (a == 2 || a == 3)             return "R2";
        if (a <= 5)                       return "R3";
        if (a <= 11)                      return "R4";
        if (a <= 13)                      return "R5";
        if (a <= 15)                      return "R6";
        if (a <= 18)                      return "R7";
        if (a <= 21)                      return "R8";
        return "R9";
    endfunction

    // behavioural reference model, updated on every clock
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NC; i++) begin m[i] = 0; p[i] = 0; end
            keep_m = 1'b0; exp_valid = 1'b0; exp_data = 0; exp_addr = 0;
        end else begin
            exp_valid = rd_en;
            if (rd_en) begin
                exp_addr = int'(rd_addr);
                exp_data = (exp_addr < NC) ? m[exp_addr] : 0;
            end
            for (int i = 0; i < NC; i++) begin
                if (rd_en && !keep_m && int'(rd_addr) == i) m[i] = 0;
                m[i] = m[i] + p[i];
            end
            if (ctl_we) keep_m = ctl_keep;
            for (int i = 0; i < NC; i++) p[i] = 0;
            if (fr_valid) begin
                int  len;
                bit  good, crc, al;
                len  = int'(fr_len);
                crc  = fr_crc_bad;
                al   = fr_align_err;
                good = !crc && !al && !fr_symbol_err && len >= 64 && len <= 1518;
                p[0]  = good ? len : 0;
                p[1]  = good;
                p[2]  = len;
                p[3]  = 1;
                p[4]  = good && fr_bcast;
                p[5]  = good && fr_mcast;
                p[6]  = (len == 64);
                p[7]  = (len >= 65 && len <= 127);
                p[8]  = (len >= 128 && len <= 255);
                p[9]  = (len >= 256 && len <= 511);
                p[10] = (len >= 512 && len <= 1023);
                p[11] = (len >= 1024 && len <= 1518);
                p[12] = (len > 1518 && crc);
                p[13] = (len > 1518 && !crc);
                p[14] = (len < 64 && crc);
                p[15] = (len < 64 && !crc);
                p[16] = crc || al;
                p[17] = crc && !al;
                p[18] = al && !crc;
                p[19] = fr_symbol_err;
                p[20] = fr_ctrl && fr_pause;
                p[21] = fr_ctrl && !fr_pause;
            end
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            chk("R1", rd_valid0, 0);
            chk("R1", rd_data0, 0);
        end else begin
            chk("R9", rd_valid0, exp_valid);
            chk("R9", rd_valid1, exp_valid);
            if (exp_valid) begin
                chk((tag == "") ? req_of(exp_addr) : tag, rd_data0, exp_data & 64'hFFFF_FFFF);
                chk("R12", rd_data1, exp_data & 64'hFFF);
            end
        end
    end

    task automatic frame(input int len, input bit crc, input bit al, input bit sy,
                         input bit bc, input bit mc, input bit ct, input bit pa);
        fr_valid = 1'b1; fr_len = 14'(len);
        fr_crc_bad = crc; fr_align_err = al; fr_symbol_err = sy;
        fr_bcast = bc; fr_mcast = mc; fr_ctrl = ct; fr_pause = pa;
        @(negedge clk);
        fr_valid = 1'b0;
    endtask

    task automatic rd(input int a);
        rd_en = 1'b1; rd_addr = 5'(a);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd_all();
        for (int a = 0; a < 24; a++) rd(a);
        @(negedge clk);
    endtask

    task automatic set_keep(input bit k);
        ctl_we = 1'b1; ctl_keep = k;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        tag = "R1";
        rd_all();                       // every counter zero after reset
        tag = "";

        // R2..R8: directed frames covering each class and boundary
        frame(64,   0,0,0, 0,0,0,0);
        frame(65,   0,0,0, 0,0,0,0);
        frame(127,  0,0,0, 0,0,0,0);
        frame(128,  0,0,0, 1,0,0,0);
        frame(255,  0,0,0, 0,1,0,0);
        frame(256,  0,0,0, 0,0,0,0);
        frame(511,  0,0,0, 0,0,0,0);
        frame(512,  0,0,0, 1,0,0,0);
        frame(1023, 0,0,0, 0,0,0,0);
        frame(1024, 0,0,0, 0,1,0,0);
        frame(1518, 0,0,0, 0,0,0,0);
        frame(1519, 1,0,0, 0,0,0,0);    // jabber
        frame(1519, 0,0,0, 1,0,0,0);    // oversize, not a good broadcast
        frame(2000, 0,0,0, 0,0,0,0);
        frame(63,   1,0,0, 0,0,0,0);    // fragment
        frame(63,   0,0,0, 0,0,0,0);    // undersize
        frame(10,   0,0,0, 0,1,0,0);
        frame(100,  0,1,0, 0,0,0,0);    // alignment only
        frame(100,  1,1,0, 0,0,0,0);    // both errors
        frame(300,  0,0,1, 1,0,0,0);    // symbol error, not good
        frame(64,   0,0,0, 0,0,1,1);    // pause
        frame(64,   0,0,0, 0,0,1,0);    // other control
        frame(800,  1,0,0, 0,1,0,0);
        repeat (2) @(negedge clk);

        // R10: keep set, two passes return identical values
        set_keep(1'b1);
        tag = "R10";
        rd_all();
        rd_all();
        set_keep(1'b0);
        rd_all();                       // destructive pass
        rd_all();                       // all zero now
        tag = "";

        // R11: clearing read meets an increment on the same edge
        frame(200, 0,0,0, 0,0,0,0);
        tag = "R11";
        rd(3);
        rd(3);
        rd(2);
        tag = "";
        repeat (2) @(negedge clk);

        // R12: push the narrow octet counters past 4096
        for (int k = 0; k < 6; k++) frame(1500, 0,0,0, 0,0,0,0);
        repeat (2) @(negedge clk);
        tag = "R12";
        rd(0);
        rd(2);
        tag = "";

        // mixed traffic with interleaved reads and keep-bit changes
        for (int c = 0; c < 1500; c++) begin
            fr_valid      = ($urandom_range(0, 2) != 0);
            fr_len        = 14'($urandom_range(0, 2100));
            fr_crc_bad    = ($urandom_range(0, 4) == 0);
            fr_align_err  = ($urandom_range(0, 5) == 0);
            fr_symbol_err = ($urandom_range(0, 6) == 0);
            fr_bcast      = $urandom_range(0, 1) == 1;
            fr_mcast      = $urandom_range(0, 1) == 1;
            fr_ctrl       = ($urandom_range(0, 4) == 0);
            fr_pause      = $urandom_range(0, 1) == 1;
            rd_en         = ($urandom_range(0, 2) == 0);
            rd_addr       = 5'($urandom_range(0, 23));
            ctl_we        = ($urandom_range(0, 40) == 0);
            ctl_keep      = $urandom_range(0, 1) == 1;
            @(negedge clk);
        end
        fr_valid = 1'b0; rd_en = 1'b0; ctl_we = 1'b0;
        repeat (2) @(negedge clk);
        rd_all();
        set_keep(1'b0);
        rd_all();
        finish_run();
    end

endmodule